// File: doc/BRIEF.md
# Residual Matrix-Vector Update Engine

This block forms a four-element update vector for an iterative centroid fit. Each element is the dot product of one row of a 4 x 100 coefficient matrix with a residual vector, where every residual entry is an observed sample minus a modelled sample. Arithmetic is signed fixed point: inputs are Q16.16, each product is formed at full width and scaled back to Q16.16, and the running sums live in 48-bit accumulators. The finished sums are clipped to 32 bits and then mapped to node indices by subtracting a per-row origin, multiplying by a per-row reciprocal step and rounding half away from zero.

The loop over columns is the outer loop. Each accepted column carries one observation, one model sample and four coefficients, one per row lane. The residual is formed once and shared by the four row accumulators, so one column is taken per clock. A column-valid input that is low stalls the job without losing or repeating a column.

The controller has four states. IDLE waits for start (IDLE to RUN). RUN takes columns and leaves for CONVERT on the final column, when the clipped sums are registered. CONVERT registers the indices and always moves on to SIGNAL. SIGNAL raises done for its one cycle and always returns to IDLE. A start request outside IDLE has no effect.

Top module: `resid_update_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, and every result and index lane reads 0.
- R2: start_i is acted on only in IDLE. A start in RUN, CONVERT or SIGNAL neither restarts nor extends the job: exactly one done pulse follows, and the block is idle afterwards.
- R3: Row r's sum is the total over the 100 columns of the Q16.16 product coef_r[k] * (obs[k] - model[k]). The residual is 33 bits wide. The 65-bit product is shifted right arithmetically by 16, and the low 48 bits are added to a 48-bit accumulator that wraps.
- R4: The first column of a job loads each accumulator with its term. Nothing from a previous job carries over.
- R5: A cycle in RUN with col_valid_i low consumes no column. The column count is unchanged.
- R6: With col_valid_i held high from the cycle after start, the job takes one column per clock. busy_o is high for exactly 102 cycles, counting from the cycle after start.
- R7: A 48-bit sum above 2^31-1 is reported as 0x7FFFFFFF. A sum below -2^31 is reported as 0x80000000.
- R8: index_r = round(((result_r - start_r) * recip_r) / 2^32). Both operands are Q16.16. Rounding is half away from zero. The index saturates to a signed 16-bit range. It is registered one cycle after the results and otherwise holds.
- R9: result_o is registered on the clock edge that accepts the last column, and then holds until the next job's last column. done_o is high for exactly one cycle, two edges after the last column.
- R10: busy_o is high in every state except IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a job (honoured in IDLE only) |
| col_valid_i | input | 1 | Column data valid this cycle |
| obs_i | input | 32 | Observed sample, Q16.16 |
| model_i | input | 32 | Modelled sample, Q16.16 |
| coef_lanes_i | input | 128 | Four coefficient lanes, row r at bits [32r+31:32r] |
| node_start_i | input | 128 | Per-row index origin, Q16.16, same lane layout |
| step_recip_i | input | 128 | Per-row reciprocal of step, Q16.16, same lane layout |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Four clipped sums, Q16.16, row r at [32r+31:32r] |
| index_o | output | 64 | Four signed node indices, row r at [16r+15:16r] |

## Verification
Two pairs of events are forced to share a cycle. The first is a start request landing on a RUN, CONVERT or SIGNAL cycle. It is judged by the per-clock model, which ignores it, and by a count showing a single done pulse. The second is a stall placed directly before the final column. It is judged by requiring that result_o changes only on the edge where the hundredth column is actually taken. A behavioural reference model advances on every clock and predicts busy, done, all four results and all four indices. It is compared against the ports at every falling edge. Dedicated jobs aim at saturation in both directions and at exact half-step rounding ties.

// File: rtl/rue_pkg.sv
package rue_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_CONVERT = 2'd2,
        ST_SIGNAL  = 2'd3
    } rue_state_t;
endpackage

// File: rtl/rue_ctrl.sv
module rue_ctrl
    import rue_pkg::*;
#(
    parameter int COLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic col_valid_i,
    output logic accept_o,
    output logic first_o,
    output logic last_o,
    output logic convert_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    rue_state_t state_q, state_d;
    logic [CW-1:0] col_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_RUN;
            ST_RUN:     if (col_valid_i && col_q == LAST_COL) state_d = ST_CONVERT;
            ST_CONVERT: state_d = ST_SIGNAL;
            ST_SIGNAL:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o  = 1'b0;
        first_o   = 1'b0;
        last_o    = 1'b0;
        convert_o = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_RUN: begin
                accept_o = col_valid_i;
                first_o  = col_valid_i && (col_q == '0);
                last_o   = col_valid_i && (col_q == LAST_COL);
            end
            ST_CONVERT: convert_o = 1'b1;
            ST_SIGNAL:  done_o    = 1'b1;
            default:    busy_o    = 1'b0;
        endcase
    end

    // column counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) col_q <= '0;
        else if (accept_o)                col_q <= last_o ? '0 : col_q + 1'b1;
    end

    a_r6_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !last_o) |=> col_q == CW'($past(col_q) + 1'b1));
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !col_valid_i) |=> $stable(col_q));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_o) |=> state_q == ST_RUN);
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/rue_mac_lane.sv
module rue_mac_lane #(
    parameter int DW   = 32,
    parameter int FRAC = 16,
    parameter int ACCW = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                first_i,
    input  logic                last_i,
    input  logic [DW-1:0]       coef_i,
    input  logic signed [DW:0]  resid_i,
    output logic [DW-1:0]       result_o
);
    localparam int PW = 2 * DW + 1;
    localparam logic signed [ACCW-1:0] SMAX = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] SMIN = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] term;
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] sum;
    logic                   fits;
    logic [DW-1:0]          clipped;

    always_comb begin
        prod    = $signed(coef_i) * resid_i;
        term    = ACCW'(prod >>> FRAC);
        sum     = (first_i ? '0 : acc_q) + term;
        fits    = (sum <= SMAX) && (sum >= SMIN);
        clipped = fits ? sum[DW-1:0] : (sum[ACCW-1] ? SMIN[DW-1:0] : SMAX[DW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            result_o <= '0;
        end else begin
            if (accept_i) acc_q    <= sum;
            if (last_i)   result_o <= clipped;
        end
    end

    a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !fits && !sum[ACCW-1]) |=> result_o == SMAX[DW-1:0]);
    a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !fits && sum[ACCW-1]) |=> result_o == SMIN[DW-1:0]);
    a_r4_first_load: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && first_i) |=> acc_q == $past(term));
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(result_o));
endmodule

// File: rtl/rue_index_conv.sv
module rue_index_conv #(
    parameter int DW   = 32,
    parameter int FRAC = 16,
    parameter int IDXW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DW-1:0]   result_i,
    input  logic [DW-1:0]   base_i,
    input  logic [DW-1:0]   recip_i,
    output logic [IDXW-1:0] index_o
);
    localparam int PW = 2 * DW + 2;
    localparam logic [PW-1:0] HALF    = PW'(1) << (2 * FRAC - 1);
    localparam logic [PW-1:0] POS_LIM = (PW'(1) << (IDXW - 1)) - PW'(1);
    localparam logic [PW-1:0] NEG_LIM = PW'(1) << (IDXW - 1);
    localparam logic [IDXW-1:0] IMAX = {1'b0, {(IDXW-1){1'b1}}};
    localparam logic [IDXW-1:0] IMIN = {1'b1, {(IDXW-1){1'b0}}};

    logic signed [DW:0]   diff;
    logic signed [PW-1:0] prod;
    logic                 neg;
    logic [PW-1:0]        mag;
    logic [PW-1:0]        qmag;
    logic [IDXW-1:0]      idx_d;

    always_comb begin
        diff = $signed(result_i) - $signed(base_i);
        prod = diff * $signed(recip_i);
        neg  = prod[PW-1];
        mag  = neg ? PW'(-prod) : PW'(prod);
        qmag = (mag + HALF) >> (2 * FRAC);
        if (neg) idx_d = (qmag > NEG_LIM) ? IMIN : (~qmag[IDXW-1:0]) + 1'b1;
        else     idx_d = (qmag > POS_LIM) ? IMAX : qmag[IDXW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      index_o <= '0;
        else if (load_i) index_o <= idx_d;
    end

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(index_o));
    a_r8_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !neg && qmag != '0) |=> !index_o[IDXW-1]);
endmodule

// File: rtl/resid_update_engine.sv
module resid_update_engine #(
    parameter int ROWS = 4,
    parameter int COLS = 100,
    parameter int DW   = 32,
    parameter int FRAC = 16,
    parameter int ACCW = 48,
    parameter int IDXW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 col_valid_i,
    input  logic [DW-1:0]        obs_i,
    input  logic [DW-1:0]        model_i,
    input  logic [ROWS*DW-1:0]   coef_lanes_i,
    input  logic [ROWS*DW-1:0]   node_start_i,
    input  logic [ROWS*DW-1:0]   step_recip_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [ROWS*DW-1:0]   result_o,
    output logic [ROWS*IDXW-1:0] index_o
);
    logic accept, first, last, convert;
    logic signed [DW:0] resid;

    // one residual per column, shared by every row lane
    assign resid = $signed(obs_i) - $signed(model_i);

    rue_ctrl #(.COLS(COLS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .col_valid_i(col_valid_i),
        .accept_o   (accept),
        .first_o    (first),
        .last_o     (last),
        .convert_o  (convert),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        rue_mac_lane #(.DW(DW), .FRAC(FRAC), .ACCW(ACCW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .accept_i(accept),
            .first_i (first),
            .last_i  (last),
            .coef_i  (coef_lanes_i[r*DW +: DW]),
            .resid_i (resid),
            .result_o(result_o[r*DW +: DW])
        );
        rue_index_conv #(.DW(DW), .FRAC(FRAC), .IDXW(IDXW)) u_idx (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (convert),
            .result_i(result_o[r*DW +: DW]),
            .base_i  (node_start_i[r*DW +: DW]),
            .recip_i (step_recip_i[r*DW +: DW]),
            .index_o (index_o[r*IDXW +: IDXW])
        );
    end
endmodule

// File: tb/tb_resid_update_engine.sv
module tb_resid_update_engine;
    localparam int ROWS = 4;
    localparam int COLS = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic valid = 1'b0;
    logic [31:0] obs = '0, mdl = '0;
    logic [31:0] coef [ROWS];
    logic [31:0] base [ROWS];
    logic [31:0] recip [ROWS];
    logic [ROWS*32-1:0] coef_f, base_f, recip_f, result_w;
    logic [ROWS*16-1:0] index_w;
    logic busy_w, done_w;

    for (genvar r = 0; r < ROWS; r++) begin : g_pack
        assign coef_f[r*32 +: 32]  = coef[r];
        assign base_f[r*32 +: 32]  = base[r];
        assign recip_f[r*32 +: 32] = recip[r];
    end

    always #5 clk = ~clk;

    resid_update_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .col_valid_i(valid),
        .obs_i(obs), .model_i(mdl), .coef_lanes_i(coef_f),
        .node_start_i(base_f), .step_recip_i(recip_f),
        .busy_o(busy_w), .done_o(done_w), .result_o(result_w), .index_o(index_w)
    );

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int busy_cycles = 0;
    bit cmp_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_state = 0;
    int m_cnt = 0;
    logic signed [47:0] m_acc [ROWS];
    logic [31:0] m_res [ROWS];
    logic [15:0] m_idx [ROWS];

    function automatic logic [31:0] m_sat(input logic signed [47:0] a);
        if (a > 48'sh0000_7FFF_FFFF) return 32'h7FFF_FFFF;
        if (a < $signed(48'hFFFF_8000_0000)) return 32'h8000_0000;
        return a[31:0];
    endfunction

    function automatic logic [15:0] m_conv(input logic [31:0] res, input logic [31:0] b, input logic [31:0] rc);
        longint d;
        logic signed [127:0] p, q;
        d = longint'($signed(res)) - longint'($signed(b));
        p = d * $signed(rc);
        if (p < 0) q = -((-p + 128'sd2147483648) >>> 32);
        else       q = (p + 128'sd2147483648) >>> 32;
        if (q > 32767)  return 16'h7FFF;
        if (q < -32768) return 16'h8000;
        return q[15:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0;
            for (int r = 0; r < ROWS; r++) begin m_acc[r] = '0; m_res[r] = '0; m_idx[r] = '0; end
        end else begin
            case (m_state)
                0: if (start) begin m_state = 1; m_cnt = 0; end
                1: if (valid) begin
                    longint rs;
                    rs = longint'($signed(obs)) - longint'($signed(mdl));
                    for (int r = 0; r < ROWS; r++) begin
                        logic signed [127:0] pp;
                        pp = $signed(coef[r]) * rs;
                        pp = pp >>> 16;
                        m_acc[r] = ((m_cnt == 0) ? 48'sd0 : m_acc[r]) + pp[47:0];
                    end
                    if (m_cnt == COLS - 1) begin
                        for (int r = 0; r < ROWS; r++) m_res[r] = m_sat(m_acc[r]);
                        m_state = 2;
                    end else m_cnt++;
                end
                2: begin
                    for (int r = 0; r < ROWS; r++) m_idx[r] = m_conv(m_res[r], base[r], recip[r]);
                    m_state = 3;
                end
                default: m_state = 0;
            endcase
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (cmp_en) begin
            if (done_w) done_seen++;
            if (busy_w) busy_cycles++;
            chk(busy_w == (m_state != 0), "R10 busy", 64'(busy_w), 64'(m_state != 0));
            chk(done_w == (m_state == 3), "R9 done", 64'(done_w), 64'(m_state == 3));
            for (int r = 0; r < ROWS; r++) begin
                chk(result_w[r*32 +: 32] == m_res[r], "R3 result", 64'(result_w[r*32 +: 32]), 64'(m_res[r]));
                chk(index_w[r*16 +: 16] == m_idx[r], "R8 index", 64'(index_w[r*16 +: 16]), 64'(m_idx[r]));
            end
        end
    end

    function automatic logic [31:0] srnd(input int span);
        int v;
        v = int'($urandom_range(2 * span)) - span;
        return 32'(v);
    endfunction

    // kind: 0 random, 1 saturation, 2 zero coefficients
    task automatic set_col(input int kind);
        if (kind == 1) begin
            obs = 32'h0080_0000; mdl = 32'hFF80_0000;
            coef[0] = 32'h0100_0000; coef[1] = 32'hFF00_0000;
            coef[2] = 32'h0000_0000; coef[3] = 32'h0001_0000;
        end else begin
            obs = srnd(1 << 20); mdl = srnd(1 << 20);
            for (int r = 0; r < ROWS; r++) coef[r] = (kind == 2) ? 32'h0 : srnd(1 << 17);
        end
    endtask

    task automatic run_job(input int kind, input int gap_mod, input bit extra_start);
        int k;
        int cyc;
        done_seen = 0;
        busy_cycles = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        cyc = 0;
        while (k < COLS) begin
            cyc++;
            if (gap_mod != 0 && (cyc % gap_mod) == 1) valid = 1'b0;
            else if (gap_mod != 0 && k == COLS - 1 && valid) valid = 1'b0;
            else begin valid = 1'b1; set_col(kind); k++; end
            start = extra_start && (cyc % 7 == 3);
            @(negedge clk);
        end
        valid = 1'b0;
        start = extra_start;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R6 watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            coef[r] = '0; base[r] = 32'h0001_0000 * r; recip[r] = 32'h0000_4000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_w == 0 && done_w == 0, "R1 ctrl reset", {busy_w, done_w}, 0);
        chk(result_w == '0, "R1 result reset", result_w[63:0], 0);
        chk(index_w == '0, "R1 index reset", index_w, 0);
        cmp_en = 1'b1;

        // R6: continuous column stream
        run_job(0, 0, 1'b0);
        chk(busy_cycles == COLS + 2, "R6 throughput", busy_cycles, COLS + 2);
        chk(done_seen == 1, "R9 one done", done_seen, 1);

        // R5 stalls plus R2 start requests while busy
        run_job(0, 3, 1'b1);
        chk(done_seen == 1, "R2 single done", done_seen, 1);
        chk(busy_w == 0, "R2 idle after", busy_w, 0);
        chk(busy_cycles > COLS + 2, "R5 stall stretch", busy_cycles, COLS + 3);

        // R4 back-to-back job, no carry-over
        run_job(0, 5, 1'b0);
        chk(done_seen == 1, "R4 done", done_seen, 1);

        // R7 saturation in both directions
        for (int r = 0; r < ROWS; r++) begin base[r] = '0; recip[r] = 32'h0000_0001; end
        run_job(1, 0, 1'b0);
        chk(result_w[31:0] == 32'h7FFF_FFFF, "R7 high clip", result_w[31:0], 32'h7FFF_FFFF);
        chk(result_w[63:32] == 32'h8000_0000, "R7 low clip", result_w[63:32], 32'h8000_0000);
        chk(result_w[127:96] == 32'h0064_0000 * 32'd256, "R7 in range", result_w[127:96], 32'h6400_0000);

        // R8 rounding ties and saturation, results forced to zero
        base[0] = 32'hFFFD_8000; recip[0] = 32'h0001_0000; // +2.5 -> 3
        base[1] = 32'h0002_8000; recip[1] = 32'h0001_0000; // -2.5 -> -3
        base[2] = 32'hFFFD_C000; recip[2] = 32'h0001_0000; // +2.25 -> 2
        base[3] = 32'hFE0C_0000; recip[3] = 32'h0064_0000; // 50000 -> clip
        run_job(2, 0, 1'b0);
        chk(result_w == '0, "R3 zero coef", result_w[63:0], 0);
        chk(index_w[15:0] == 16'd3, "R8 tie up", index_w[15:0], 3);
        chk(index_w[31:16] == 16'hFFFD, "R8 tie away", index_w[31:16], 16'hFFFD);
        chk(index_w[47:32] == 16'd2, "R8 below half", index_w[47:32], 2);
        chk(index_w[63:48] == 16'h7FFF, "R8 index clip", index_w[63:48], 16'h7FFF);

        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule